// File: doc/BRIEF.md
# Open-Drain Quasi-Bidirectional Port Controller

This block holds the output latches and the pad-control logic for two 8-bit memory-mapped I/O ports on a small microcontroller. Every writable pin is open-drain. A latch value of 0 turns on the NMOS pull-down. A latch value of 1 releases the pin, which then floats high through a pull-up and can be read as an input. A CPU read always returns the live pad levels, never the latch contents. Set-bit, clear-bit and complement operations therefore start from the pad levels. The modified byte is then written back into the latches.

Port A has eight open-drain bits. Port B has two open-drain bits (0 and 1), five input-only bits with pull-ups (2 to 6), and one input-only bit with no pull-up (7). Each port B line has its own wake-up enable bit. A low level on any enabled line raises a synchronised, level-based wake-up request.

Each CPU access runs through a three-state sequencer:
- `ST_IDLE` accepts a request. Transition: `accept`, from IDLE to SAMPLE when `cpu_req` is high.
- `ST_SAMPLE` captures the pads of the addressed port at its closing clock edge. Transition: `snap`, from SAMPLE to COMMIT.
- `ST_COMMIT` writes the latch if the operation modifies it. Transition: `retire`, from COMMIT to IDLE.

Top module: `qbio_port_ctrl`

## Requirements
- R1: After reset, every writable latch holds 1. `pd_en_a` and `pd_en_b` are 0x00, `pu_en_a` is 0xFF, `pu_en_b` is 0x7F, `cpu_ready` is 1 and `cpu_rdata` is 0x00.
- R2: Address 0x12 selects port A and address 0x14 selects port B. An access to any other address leaves every latch unchanged and returns `cpu_rdata` = 0x00.
- R3: A request is accepted only while `cpu_ready` is high, which is only in IDLE. The access then passes through SAMPLE and COMMIT and returns to IDLE. A request made while the sequencer is busy is ignored.
- R4: `cpu_rdata` takes the addressed port's pad levels at the clock edge that ends SAMPLE, one edge after acceptance. It then holds that value until the next access samples again.
- R5: Operation code 1 (write) loads `cpu_wdata` into the addressed latches at the edge that ends COMMIT. Each open-drain bit drives `pd_en` = NOT latch.
- R6: Operation codes 2 (set bit `cpu_bit`), 3 (clear bit `cpu_bit`) and 4 (invert all bits) take the sampled pad byte, modify it, and write the result into the latches. An open-drain bit that was held low externally is therefore written back as 0.
- R7: On port B only bits 0 and 1 are writable. `pd_en_b` bits 7 to 2 are always 0. A read of port B returns the pad levels of all eight bits.
- R8: `pu_en` is the inverse of `pd_en` for every port A bit and for port B bits 0 and 1. `pu_en_b` bits 6 to 2 are always 1, and `pu_en_b` bit 7 is always 0.
- R9: `wake_req` goes high two clock edges after some port B pad is low while its `wake_cfg` bit is 1. It goes low two edges after no enabled line is low. A low line whose enable bit is 0 has no effect.
- R10: Operation code 0 (read) and the unused codes 5 to 7 never change a latch. A latch changes only in COMMIT of a write or modify operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access strobe, taken while `cpu_ready` is high |
| cpu_addr | input | 8 | Data-memory address |
| cpu_op | input | 3 | Operation: 0 read, 1 write, 2 set bit, 3 clear bit, 4 invert; 5 to 7 act as read |
| cpu_bit | input | 3 | Bit index for set and clear |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Sampled pad byte of the last access |
| cpu_ready | output | 1 | High in IDLE |
| pad_in_a | input | 8 | Port A pad levels |
| pad_in_b | input | 8 | Port B pad levels |
| wake_cfg | input | 8 | Wake-up enable, one bit for each port B line |
| pd_en_a | output | 8 | Port A NMOS pull-down enables |
| pd_en_b | output | 8 | Port B NMOS pull-down enables |
| pu_en_a | output | 8 | Port A pull-up enables |
| pu_en_b | output | 8 | Port B pull-up enables |
| wake_req | output | 1 | Synchronised wake-up request |

## Verification
The bench models each pad as a wired level: the pad is high only if the pull-down is off and the external driver releases the line. This lets writes, reads and modify operations be tried with pads that agree with the latches and with pads that an external driver holds low. A set-bit on one bit while another bit is held low externally separates a pad-based modify from a latch-based one. Inverting port B separates writable bits from input-only bits. A request issued while the sequencer is busy, accesses to an unmapped address, and the read and unused operation codes show that nothing outside COMMIT of a modifying operation reaches the latches. Wake-up is driven from an enabled line and from a disabled line, and is checked at each of the two synchroniser edges.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    localparam logic [2:0] OP_READ  = 3'd0;
    localparam logic [2:0] OP_WRITE = 3'd1;
    localparam logic [2:0] OP_SETB  = 3'd2;
    localparam logic [2:0] OP_CLRB  = 3'd3;
    localparam logic [2:0] OP_CPL   = 3'd4;
endpackage

// File: rtl/qbio_seq.sv
module qbio_seq
    import qbio_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int BW = $clog2(DW),
    parameter logic [AW-1:0] ADDR_A = 8'h12,
    parameter logic [AW-1:0] ADDR_B = 8'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    op,
    input  logic [BW-1:0] bitsel,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          sample_en,
    output logic          commit_en,
    output logic          sel_a,
    output logic          sel_b,
    output logic [2:0]    op_q,
    output logic [BW-1:0] bit_q,
    output logic [DW-1:0] wdata_q
);
    seq_state_e state, state_nx;
    logic accept;

    assign accept = (state == ST_IDLE) && req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, snap, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req) state_nx = ST_SAMPLE;
            ST_SAMPLE: state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        sample_en = 1'b0;
        commit_en = 1'b0;
        unique case (state)
            ST_IDLE:   ready     = 1'b1;
            ST_SAMPLE: sample_en = 1'b1;
            ST_COMMIT: commit_en = 1'b1;
            default:   ready     = 1'b0;
        endcase
    end

    // request fields captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_a   <= 1'b0;
            sel_b   <= 1'b0;
            op_q    <= OP_READ;
            bit_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            sel_a   <= (addr == ADDR_A);
            sel_b   <= (addr == ADDR_B);
            op_q    <= op;
            bit_q   <= bitsel;
            wdata_q <= wdata;
        end
    end
endmodule

// File: rtl/qbio_latch.sv
module qbio_latch #(
    parameter int W = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  q[i] <= 1'b1;
                else if (we) q[i] <= d[i];
            end
        end else begin : g_fixed
            assign q[i] = 1'b1;
        end
    end
endmodule

// File: rtl/qbio_wake.sv
module qbio_wake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] pads,
    output logic         wake
);
    logic hit, sync1;

    assign hit = |(enable & ~pads);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            wake  <= 1'b0;
        end else begin
            sync1 <= hit;
            wake  <= sync1;
        end
    end
endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl
    import qbio_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] ADDR_A = 8'h12,
    parameter logic [AW-1:0] ADDR_B = 8'h14,
    parameter logic [DW-1:0] B_OUT_MASK  = 8'h03,
    parameter logic [DW-1:0] B_PULL_MASK = 8'h7F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic [2:0]    cpu_op,
    input  logic [$clog2(DW)-1:0] cpu_bit,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    input  logic [DW-1:0] pad_in_a,
    input  logic [DW-1:0] pad_in_b,
    input  logic [DW-1:0] wake_cfg,
    output logic [DW-1:0] pd_en_a,
    output logic [DW-1:0] pd_en_b,
    output logic [DW-1:0] pu_en_a,
    output logic [DW-1:0] pu_en_b,
    output logic          wake_req
);
    localparam int BW = $clog2(DW);
    localparam logic [DW-1:0] A_MASK = '1;
    localparam logic [DW-1:0] B_FIXED_PU = B_PULL_MASK & ~B_OUT_MASK;

    logic          sample_en, commit_en, sel_a, sel_b;
    logic [2:0]    op_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] wdata_q, new_val, bit_hot, lat_a, lat_b;
    logic          modifies;

    qbio_seq #(.AW(AW), .DW(DW), .BW(BW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .addr(cpu_addr), .op(cpu_op),
        .bitsel(cpu_bit), .wdata(cpu_wdata), .ready(cpu_ready),
        .sample_en(sample_en), .commit_en(commit_en), .sel_a(sel_a), .sel_b(sel_b),
        .op_q(op_q), .bit_q(bit_q), .wdata_q(wdata_q)
    );

    // pad snapshot taken at the edge that ends SAMPLE; doubles as read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_rdata <= '0;
        else if (sample_en) begin
            if (sel_a)      cpu_rdata <= pad_in_a;
            else if (sel_b) cpu_rdata <= pad_in_b;
            else            cpu_rdata <= '0;
        end
    end

    // modify step works from the pad snapshot
    assign bit_hot = {{(DW-1){1'b0}}, 1'b1} << bit_q;

    always_comb begin
        new_val  = cpu_rdata;
        modifies = 1'b1;
        case (op_q)
            OP_WRITE: new_val = wdata_q;
            OP_SETB:  new_val = cpu_rdata | bit_hot;
            OP_CLRB:  new_val = cpu_rdata & ~bit_hot;
            OP_CPL:   new_val = ~cpu_rdata;
            default:  modifies = 1'b0;
        endcase
    end

    qbio_latch #(.W(DW), .MASK(A_MASK)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .we(commit_en && sel_a && modifies),
        .d(new_val), .q(lat_a)
    );

    qbio_latch #(.W(DW), .MASK(B_OUT_MASK)) u_lat_b (
        .clk(clk), .rst_n(rst_n), .we(commit_en && sel_b && modifies),
        .d(new_val), .q(lat_b)
    );

    assign pd_en_a = ~lat_a;
    assign pu_en_a = lat_a;
    assign pd_en_b = ~lat_b & B_OUT_MASK;
    assign pu_en_b = (lat_b & B_OUT_MASK) | B_FIXED_PU;

    qbio_wake #(.W(DW)) u_wake (
        .clk(clk), .rst_n(rst_n), .enable(wake_cfg), .pads(pad_in_b), .wake(wake_req)
    );
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_ready,
    input logic [DW-1:0] cpu_rdata,
    input logic [DW-1:0] pad_in_b,
    input logic [DW-1:0] wake_cfg,
    input logic [DW-1:0] pd_en_a,
    input logic [DW-1:0] pd_en_b,
    input logic [DW-1:0] pu_en_a,
    input logic [DW-1:0] pu_en_b,
    input logic          wake_req
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ready |=> !cpu_ready);

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && $past(cpu_ready) |-> $stable(pd_en_a) && $stable(pd_en_b));

    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && $past(cpu_ready) |-> $stable(cpu_rdata));

    assert_pull_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pd_en_a & pu_en_a) == '0) && (pu_en_b[6:2] == 5'h1F) && !pu_en_b[7]);

    assert_b_input_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en_b[7:2] == 6'h00);

    assert_wake_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd3 |-> wake_req == $past(|(wake_cfg & ~pad_in_b), 2));
endmodule

bind qbio_port_ctrl qbio_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .pad_in_b(pad_in_b), .wake_cfg(wake_cfg),
    .pd_en_a(pd_en_a), .pd_en_b(pd_en_b), .pu_en_a(pu_en_a), .pu_en_b(pu_en_b),
    .wake_req(wake_req)
);

// File: tb/qbio_port_ctrl_test.sv
`timescale 1ns/1ps
module qbio_port_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [2:0] cpu_op = 3'd0;
    logic [2:0] cpu_bit = 3'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;
    logic [7:0] ext_a = 8'hFF, ext_b = 8'hFF, wake_cfg = 8'h00;
    logic [7:0] pad_in_a, pad_in_b, pd_en_a, pd_en_b, pu_en_a, pu_en_b;
    logic       wake_req;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    // wired pad: high only if neither pull-down nor external driver pulls it low
    assign pad_in_a = ext_a & ~pd_en_a;
    assign pad_in_b = ext_b & ~pd_en_b;

    qbio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_op(cpu_op), .cpu_bit(cpu_bit), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .pad_in_a(pad_in_a),
        .pad_in_b(pad_in_b), .wake_cfg(wake_cfg), .pd_en_a(pd_en_a),
        .pd_en_b(pd_en_b), .pu_en_a(pu_en_a), .pu_en_b(pu_en_b), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one access: request at a falling edge, done three falling edges later
    task automatic access(input logic [7:0] a, input logic [2:0] op,
                          input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_op = op; cpu_bit = b; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pd_en_a", pd_en_a, 8'h00);
        check("R1 pd_en_b", pd_en_b, 8'h00);
        check("R1 pu_en_a", pu_en_a, 8'hFF);
        check("R1 pu_en_b", pu_en_b, 8'h7F);
        check("R1 ready", {7'd0, cpu_ready}, 8'h01);
        check("R1 rdata", cpu_rdata, 8'h00);
    endtask

    task automatic t_write_read_a;
        access(8'h12, 3'd1, 3'd0, 8'h5A);
        check("R5 pd_en_a", pd_en_a, 8'hA5);
        check("R8 pu_en_a", pu_en_a, 8'h5A);
        ext_a = 8'h0F;
        access(8'h12, 3'd0, 3'd0, 8'h00);
        check("R4 read pads", cpu_rdata, 8'h0A);
        check("R10 read keeps latch", pd_en_a, 8'hA5);
        ext_a = 8'hFF;
        repeat (3) @(negedge clk);
        check("R4 rdata held", cpu_rdata, 8'h0A);
    endtask

    task automatic t_rmw_a;
        access(8'h12, 3'd1, 3'd0, 8'hFF);
        ext_a = 8'hF7;
        access(8'h12, 3'd2, 3'd0, 8'h00);
        check("R6 set from pads", pd_en_a, 8'h08);
        ext_a = 8'hFF;
        access(8'h12, 3'd3, 3'd7, 8'h00);
        check("R6 clear bit7", pd_en_a, 8'h88);
        access(8'h12, 3'd4, 3'd0, 8'h00);
        check("R6 invert", pd_en_a, 8'h77);
        check("R8 pu after invert", pu_en_a, 8'h88);
    endtask

    task automatic t_port_b;
        access(8'h14, 3'd1, 3'd0, 8'h00);
        check("R7 write b", pd_en_b, 8'h03);
        check("R8 pu b", pu_en_b, 8'h7C);
        ext_b = 8'h5F;
        access(8'h14, 3'd0, 3'd0, 8'h00);
        check("R7 read b pads", cpu_rdata, 8'h5C);
        ext_b = 8'hFF;
        access(8'h14, 3'd1, 3'd0, 8'hFF);
        access(8'h14, 3'd4, 3'd0, 8'h00);
        check("R7 invert b", pd_en_b, 8'h03);
        access(8'h14, 3'd1, 3'd0, 8'hFF);
        check("R7 restore b", pd_en_b, 8'h00);
    endtask

    task automatic t_decode;
        access(8'h12, 3'd1, 3'd0, 8'hFF);
        access(8'h13, 3'd1, 3'd0, 8'h00);
        check("R2 other addr a", pd_en_a, 8'h00);
        check("R2 other addr b", pd_en_b, 8'h00);
        check("R2 other addr rdata", cpu_rdata, 8'h00);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 8'h12; cpu_op = 3'd1; cpu_wdata = 8'h00;
        @(negedge clk);
        check("R3 busy", {7'd0, cpu_ready}, 8'h00);
        cpu_addr = 8'h14;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        check("R3 first request", pd_en_a, 8'hFF);
        check("R3 busy request ignored", pd_en_b, 8'h00);
        check("R3 back to idle", {7'd0, cpu_ready}, 8'h01);
        access(8'h12, 3'd1, 3'd0, 8'hFF);
    endtask

    task automatic t_unused_op;
        access(8'h12, 3'd5, 3'd0, 8'h00);
        check("R10 unused op", pd_en_a, 8'h00);
    endtask

    task automatic t_wake;
        wake_cfg = 8'h80;
        ext_b = 8'hEF;
        repeat (3) @(negedge clk);
        check("R9 disabled line", {7'd0, wake_req}, 8'h00);
        ext_b = 8'h7F;
        @(negedge clk);
        check("R9 first edge", {7'd0, wake_req}, 8'h00);
        @(negedge clk);
        check("R9 second edge", {7'd0, wake_req}, 8'h01);
        ext_b = 8'hFF;
        @(negedge clk);
        check("R9 release first", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R9 release second", {7'd0, wake_req}, 8'h00);
        wake_cfg = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read_a();
        t_rmw_a();
        t_port_b();
        t_decode();
        t_busy_ignore();
        t_unused_op();
        t_wake();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #20000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule